// File: doc/BRIEF.md
# Character Video Timing Controller: Processor Register Port

This block is the processor-facing side of a character-oriented video timing controller. It sits on a 16-bit I/O bus that has no direction signal. Each I/O request is classified from the address alone into one of four accesses: load the register index, write data to the indexed register, read status, or read the indexed register. It holds the 5-bit index and sixteen writable timing registers, and presents them on a flat bus to the timing counters. It also holds the two light-pen address registers and, in one variant, a status flag register.

A single parameter picks between two read-back variants. Variant A lets software read the start address and has no status flags. Variant B hides the start address and returns all ones from index 31. It also provides a status byte carrying a light-pen flag that clears itself and a live vertical-border flag.

Each access runs through a small state machine. In state ST_IDLE no access is pending. A selected request moves the machine to ST_INDEX, ST_WRITE, ST_STATUS or ST_READ according to address bits 9:8. Any cycle without a selected request returns it to ST_IDLE. The access takes effect at the clock edge that ends the state, so a request sampled at edge N is complete after edge N+1.

Top module: `crtc_cpu_port`

## Requirements
- R1: A request with `io_addr[14]`=1 has no effect. No register, index, flag or `io_rdata` changes.
- R2: With `io_addr[14]`=0 the access is chosen by `io_addr[9:8]` alone: 00 index load, 01 data write, 10 status read, 11 register read. There is no direction input. `io_rdata` updates only at the edge after a read or status request has been sampled, and otherwise holds its value.
- R3: An index load stores `io_wdata[4:0]` as the 5-bit register index.
- R4: Data writes to indices 0 to 15 store the value masked to the implemented bits. Indices 4, 6 and 7 keep 7 bits. Indices 5, 9, 10 and 11 keep 5 bits. Indices 12 and 14 keep 6 bits. The rest keep 8 bits. Register k appears on `tmg_regs[8k+7:8k]`.
- R5: Register reads of indices 0 to 11 return 0. Indices 14 and 15 return the stored value.
- R6: Indices 12 and 13 read back their stored value on variant A and read as 0 on variant B.
- R7: A rising edge of `lpen_strobe` loads index 16 with {2'b00, `cur_ma[13:8]`} and index 17 with `cur_ma[7:0]`. Both read back on both variants, and data writes to them are ignored.
- R8: Indices 18 to 30 read as 0. Index 31 reads 0 on variant A and 8'hFF on variant B. Data writes to indices 18 to 31 are discarded.
- R9: On variant B, status bit 6 is set by a light-pen rising edge and cleared by a register read of index 16 or 17. If both happen at the same edge, the flag ends set.
- R10: On variant B, a status read returns `vborder` in bit 5, the light-pen flag in bit 6, and 0 in all other bits. On variant A a status read returns 0.
- R11: After reset the index, all registers, the light-pen flag and `io_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_req | input | 1 | I/O request present this cycle |
| io_addr | input | 16 | I/O address; bit 14 selects, bits 9:8 choose the access |
| io_wdata | input | 8 | Data bus value used by index loads and data writes |
| io_rdata | output | 8 | Registered read data |
| lpen_strobe | input | 1 | Light-pen strobe, rising edge captures the address |
| cur_ma | input | 14 | Current memory address from the timing counters |
| vborder | input | 1 | High while the vertical border is active |
| tmg_regs | output | 128 | Timing registers 0 to 15, eight bits each |

## Verification
Two functions can fall on the same clock edge: the execution of a register read of index 16 or 17, and a light-pen rising edge. The read clears the flag and returns the captured address, while the strobe sets the flag and recaptures the address. The bench provokes this by raising the strobe in the cycle between sampling such a read and executing it. It then judges that the read returned the old address, that the registers now hold the new address, and that a following status read still shows bit 6 set. A second read without a strobe must then clear the flag.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int DW     = 8;
    localparam int IDX_W  = 5;
    localparam int NWR    = 16;
    localparam int LP_HI  = 16;
    localparam int LP_LO  = 17;
    localparam int DUMMY  = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INDEX,
        ST_WRITE,
        ST_STATUS,
        ST_READ
    } acc_state_e;

    // implemented bits of each writable timing register
    function automatic logic [DW-1:0] wr_mask(input logic [IDX_W-1:0] idx);
        logic [DW-1:0] m;
        case (idx)
            5'd4, 5'd6, 5'd7:            m = 8'h7F;
            5'd5, 5'd9, 5'd10, 5'd11:    m = 8'h1F;
            5'd12, 5'd14:                m = 8'h3F;
            default:                     m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/crtc_addr_decode.sv
module crtc_addr_decode
    import crtc_pkg::*;
#(
    parameter int AW      = 16,
    parameter int SEL_BIT = 14,
    parameter int FN_LO   = 8
) (
    input  logic          req,
    input  logic [AW-1:0] addr,
    output acc_state_e    next_state
);

    logic [1:0] fn;
    logic       sel;

    assign fn  = addr[FN_LO+1:FN_LO];
    assign sel = req && !addr[SEL_BIT];

    always_comb begin
        next_state = ST_IDLE;
        if (sel) begin
            unique case (fn)
                2'b00: next_state = ST_INDEX;
                2'b01: next_state = ST_WRITE;
                2'b10: next_state = ST_STATUS;
                2'b11: next_state = ST_READ;
            endcase
        end
    end

endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
    import crtc_pkg::*;
#(
    parameter int NREG = NWR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    regs [NREG]
);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
            localparam logic [DW-1:0]    MY_MSK = wr_mask(MY_IDX);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (we && idx == MY_IDX)
                    regs[g] <= wdata & MY_MSK;
            end
        end
    endgenerate

endmodule

// File: rtl/crtc_lpen_status.sv
module crtc_lpen_status
    import crtc_pkg::*;
#(
    parameter int MA_W     = 14,
    parameter bit HAS_FLAG = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic [MA_W-1:0] cur_ma,
    input  logic            rd_clr,
    output logic [DW-1:0]   lp_hi,
    output logic [DW-1:0]   lp_lo,
    output logic            flag
);

    localparam int HI_W = MA_W - DW;

    logic strobe_q;
    logic rise;

    assign rise = strobe && !strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            lp_hi    <= '0;
            lp_lo    <= '0;
        end else begin
            strobe_q <= strobe;
            if (rise) begin
                lp_hi <= {{(DW-HI_W){1'b0}}, cur_ma[MA_W-1:DW]};
                lp_lo <= cur_ma[DW-1:0];
            end
        end
    end

    generate
        if (HAS_FLAG) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flag <= 1'b0;
                else if (rise)
                    flag <= 1'b1;
                else if (rd_clr)
                    flag <= 1'b0;
            end
        end else begin : g_noflag
            logic unused_clr;
            assign unused_clr = rd_clr;
            assign flag = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/crtc_read_mux.sv
module crtc_read_mux
    import crtc_pkg::*;
#(
    parameter bit VARIANT_B = 1'b1,
    parameter int NREG      = NWR
) (
    input  logic             is_status,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    regs [NREG],
    input  logic [DW-1:0]    lp_hi,
    input  logic [DW-1:0]    lp_lo,
    input  logic             flag,
    input  logic             vborder,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] status_val;
    logic [DW-1:0] dummy_val;
    logic          start_readable;

    generate
        if (VARIANT_B) begin : g_var_b
            assign status_val     = {1'b0, flag, vborder, 5'b0};
            assign dummy_val      = '1;
            assign start_readable = 1'b0;
        end else begin : g_var_a
            logic unused_st;
            assign unused_st      = flag ^ vborder;
            assign status_val     = '0;
            assign dummy_val      = '0;
            assign start_readable = 1'b1;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (is_status) begin
            rdata = status_val;
        end else begin
            unique case (idx)
                5'd12, 5'd13: rdata = start_readable ? regs[idx[3:0]] : '0;
                5'd14, 5'd15: rdata = regs[idx[3:0]];
                5'd16:        rdata = lp_hi;
                5'd17:        rdata = lp_lo;
                5'd31:        rdata = dummy_val;
                default:      rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/crtc_cpu_port.sv
module crtc_cpu_port
    import crtc_pkg::*;
#(
    parameter bit VARIANT_B = 1'b1,
    parameter int AW        = 16,
    parameter int MA_W      = 14,
    parameter int NREG      = NWR,
    localparam int REGS_W   = NREG * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic [AW-1:0]     io_addr,
    input  logic [DW-1:0]     io_wdata,
    output logic [DW-1:0]     io_rdata,
    input  logic              lpen_strobe,
    input  logic [MA_W-1:0]   cur_ma,
    input  logic              vborder,
    output logic [REGS_W-1:0] tmg_regs
);

    acc_state_e        state_q, state_d;
    logic [DW-1:0]     wdata_q;
    logic [IDX_W-1:0]  index_q;
    logic [DW-1:0]     regs [NREG];
    logic [DW-1:0]     lp_hi, lp_lo, rd_val;
    logic              lp_flag;
    logic              idx_we, reg_we, rd_en, st_en, lp_clr;
    logic              unused_addr;

    assign unused_addr = ^{io_addr[AW-1:15], io_addr[13:10], io_addr[7:0]};

    crtc_addr_decode #(.AW(AW), .SEL_BIT(14), .FN_LO(8)) u_dec (
        .req        (io_req),
        .addr       (io_addr),
        .next_state (state_d)
    );

    // state register: the access sampled at this edge executes at the next
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            wdata_q <= io_wdata;
        end
    end

    // per-state actions
    always_comb begin
        idx_we = 1'b0;
        reg_we = 1'b0;
        rd_en  = 1'b0;
        st_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_INDEX:  idx_we = 1'b1;
            ST_WRITE:  reg_we = (index_q < IDX_W'(NREG));
            ST_STATUS: st_en  = 1'b1;
            ST_READ:   rd_en  = 1'b1;
            default:   ;
        endcase
    end

    assign lp_clr = rd_en && (index_q == IDX_W'(LP_HI) || index_q == IDX_W'(LP_LO));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            index_q <= '0;
        else if (idx_we)
            index_q <= wdata_q[IDX_W-1:0];
    end

    crtc_regfile #(.NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .idx   (index_q),
        .wdata (wdata_q),
        .regs  (regs)
    );

    crtc_lpen_status #(.MA_W(MA_W), .HAS_FLAG(VARIANT_B)) u_lp (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (lpen_strobe),
        .cur_ma (cur_ma),
        .rd_clr (lp_clr),
        .lp_hi  (lp_hi),
        .lp_lo  (lp_lo),
        .flag   (lp_flag)
    );

    crtc_read_mux #(.VARIANT_B(VARIANT_B), .NREG(NREG)) u_rm (
        .is_status (st_en),
        .idx       (index_q),
        .regs      (regs),
        .lp_hi     (lp_hi),
        .lp_lo     (lp_lo),
        .flag      (lp_flag),
        .vborder   (vborder),
        .rdata     (rd_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            io_rdata <= '0;
        else if (rd_en || st_en)
            io_rdata <= rd_val;
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_flat
            assign tmg_regs[g*DW +: DW] = regs[g];
        end
    endgenerate

endmodule

// File: rtl/crtc_cpu_port_chk.sv
module crtc_cpu_port_chk
    import crtc_pkg::*;
#(
    parameter bit VARIANT_B = 1'b1,
    parameter int REGS_W    = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_req,
    input logic [15:0]       io_addr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              lpen_strobe,
    input logic [REGS_W-1:0] tmg_regs,
    input acc_state_e        state_q,
    input logic [4:0]        index_q,
    input logic              lp_flag
);

    logic strobe_seen;
    logic lp_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_seen <= 1'b0;
        else        strobe_seen <= lpen_strobe;
    end
    assign lp_rise = lpen_strobe && !strobe_seen;

    a_r1_unselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_addr[14]) |=> (state_q == ST_IDLE));

    a_r2_read_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_addr[14] && io_addr[9:8] == 2'b11) |=> (state_q == ST_READ));

    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READ && state_q != ST_STATUS) |=> $stable(io_rdata));

    a_r3_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_addr[14] && io_addr[9:8] == 2'b00) |=> ##1
            (index_q == $past(io_wdata[4:0], 2)));

    a_r4_regs_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WRITE) |=> $stable(tmg_regs));

    a_r10_status_unused_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STATUS) |=> (io_rdata[7] == 1'b0 && io_rdata[4:0] == 5'd0));

    generate
        if (VARIANT_B) begin : g_b
            a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
                lp_rise |=> lp_flag);
            a_r8_dummy_ones: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_READ && index_q == 5'd31) |=> (io_rdata == 8'hFF));
        end else begin : g_a
            a_r10_no_status: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_STATUS) |=> (io_rdata == 8'h00));
        end
    endgenerate

    logic unused_bits;
    assign unused_bits = ^{io_addr[15], io_addr[13:10], io_addr[7:0], io_wdata[7:5]};

endmodule

bind crtc_cpu_port crtc_cpu_port_chk #(.VARIANT_B(VARIANT_B), .REGS_W(REGS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_req      (io_req),
    .io_addr     (io_addr),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .lpen_strobe (lpen_strobe),
    .tmg_regs    (tmg_regs),
    .state_q     (state_q),
    .index_q     (index_q),
    .lp_flag     (lp_flag)
);

// File: tb/test_crtc_cpu_port.sv
`timescale 1ns/1ps
module test_crtc_cpu_port;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         io_req = 1'b0;
    logic [15:0]  io_addr = 16'hFFFF;
    logic [7:0]   io_wdata = 8'h00;
    logic         lpen_strobe = 1'b0;
    logic [13:0]  cur_ma = 14'd0;
    logic         vborder = 1'b0;
    logic [7:0]   rd_b, rd_a;
    logic [127:0] regs_b, regs_a;

    always #4 clk = ~clk;

    crtc_cpu_port #(.VARIANT_B(1'b1)) i_crtc_cpu_port (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(rd_b), .lpen_strobe(lpen_strobe),
        .cur_ma(cur_ma), .vborder(vborder), .tmg_regs(regs_b));

    crtc_cpu_port #(.VARIANT_B(1'b0)) i_crtc_cpu_port_a (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(rd_a), .lpen_strobe(lpen_strobe),
        .cur_ma(cur_ma), .vborder(vborder), .tmg_regs(regs_a));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_regs [16];
    logic [4:0] m_idx;
    logic [7:0] m_lphi, m_lplo;
    logic       m_flag;
    logic [7:0] m_rdb, m_rda;

    function automatic logic [7:0] exp_mask(input int i);
        if (i == 4 || i == 6 || i == 7) return 8'h7F;
        if (i == 5 || (i >= 9 && i <= 11)) return 8'h1F;
        if (i == 12 || i == 14) return 8'h3F;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] exp_read(input bit var_b, input int i);
        if (i == 12 || i == 13) return var_b ? 8'h00 : m_regs[i];
        if (i == 14 || i == 15) return m_regs[i];
        if (i == 16) return m_lphi;
        if (i == 17) return m_lplo;
        if (i == 31) return var_b ? 8'hFF : 8'h00;
        return 8'h00;
    endfunction

    function automatic logic [127:0] exp_flat();
        logic [127:0] f;
        for (int k = 0; k < 16; k++) f[k*8 +: 8] = m_regs[k];
        return f;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        n_chk++;
        if (regs_b !== exp_flat() || regs_a !== exp_flat()) begin
            n_bad++;
            $display("FAIL %s: actual %032h / %032h expected %032h", req, regs_b, regs_a, exp_flat());
        end
    endtask

    // one access: request sampled at edge 1, executed at edge 2, checked after
    task automatic access(input string req, input logic [15:0] a, input logic [7:0] d,
                          input bit strobe_mid, input logic [13:0] ma);
        @(negedge clk);
        io_req = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_req = 1'b0; io_addr = 16'hFFFF;
        if (strobe_mid) begin lpen_strobe = 1'b1; cur_ma = ma; end
        @(negedge clk);
        lpen_strobe = 1'b0;
        if (!a[14]) begin
            case (a[9:8])
                2'b00: m_idx = d[4:0];
                2'b01: if (m_idx < 16) m_regs[m_idx] = d & exp_mask(int'(m_idx));
                2'b10: begin m_rdb = {1'b0, m_flag, vborder, 5'b0}; m_rda = 8'h00; end
                default: begin
                    m_rdb = exp_read(1'b1, int'(m_idx));
                    m_rda = exp_read(1'b0, int'(m_idx));
                    if (m_idx == 5'd16 || m_idx == 5'd17) m_flag = 1'b0;
                end
            endcase
        end
        if (strobe_mid) begin
            m_lphi = {2'b00, ma[13:8]}; m_lplo = ma[7:0]; m_flag = 1'b1;
        end
        check8({req, " rdata B"}, rd_b, m_rdb);
        check8({req, " rdata A"}, rd_a, m_rda);
        check_regs({req, " regs"});
    endtask

    task automatic pulse_lpen(input logic [13:0] ma);
        @(negedge clk); lpen_strobe = 1'b1; cur_ma = ma;
        @(negedge clk); lpen_strobe = 1'b0;
        m_lphi = {2'b00, ma[13:8]}; m_lplo = ma[7:0]; m_flag = 1'b1;
    endtask

    localparam logic [15:0] A_IDX = 16'hBCFF, A_WR = 16'hBDFF,
                            A_ST  = 16'hBEFF, A_RD = 16'hBFFF;

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int k = 0; k < 16; k++) m_regs[k] = 8'h00;
        m_idx = '0; m_lphi = '0; m_lplo = '0; m_flag = 1'b0; m_rdb = '0; m_rda = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check8("R11 rdata B", rd_b, 8'h00);
        check8("R11 rdata A", rd_a, 8'h00);
        check_regs("R11");
        access("R11 status", A_ST, 8'h00, 1'b0, 14'd0);

        // R3 and R4: all-ones writes show the masks
        for (int k = 0; k < 16; k++) begin
            access("R3 index", A_IDX, 8'hE0 | 8'(k), 1'b0, 14'd0);
            access("R4 write", A_WR, 8'hFF, 1'b0, 14'd0);
        end
        // R5 R6 R8 read every index on both variants
        for (int k = 0; k < 32; k++) begin
            access("R3 index", A_IDX, 8'(k), 1'b0, 14'd0);
            access("R5 R6 R8 read", A_RD, 8'h00, 1'b0, 14'd0);
        end
        // R8 writes to 18..31 discarded, R7 writes to 16/17 ignored
        foreach (m_regs[k]) begin end
        access("R8 index", A_IDX, 8'd31, 1'b0, 14'd0);
        access("R8 write", A_WR, 8'h00, 1'b0, 14'd0);
        access("R8 read", A_RD, 8'h00, 1'b0, 14'd0);
        access("R7 index", A_IDX, 8'd16, 1'b0, 14'd0);
        access("R7 write", A_WR, 8'h3C, 1'b0, 14'd0);
        access("R7 read", A_RD, 8'h00, 1'b0, 14'd0);

        // R1 unselected requests: index load and write with bit 14 set
        access("R3 index", A_IDX, 8'd14, 1'b0, 14'd0);
        access("R1 unsel index", 16'hFCFF, 8'd15, 1'b0, 14'd0);
        access("R1 unsel write", 16'hFDFF, 8'h00, 1'b0, 14'd0);
        access("R1 unsel read", 16'hFFFF, 8'h00, 1'b0, 14'd0);
        access("R1 read after", A_RD, 8'h00, 1'b0, 14'd0);
        // R2 only bits 9:8 matter: index load with other address bits cleared
        access("R2 odd addr", 16'h0000, 8'd13, 1'b0, 14'd0);
        access("R2 odd addr rd", 16'h0300, 8'h00, 1'b0, 14'd0);

        // R7 R9 R10 light pen and status
        pulse_lpen(14'h2A5C);
        vborder = 1'b1;
        access("R9 R10 status", A_ST, 8'h00, 1'b0, 14'd0);
        vborder = 1'b0;
        access("R10 status", A_ST, 8'h00, 1'b0, 14'd0);
        access("R7 index", A_IDX, 8'd17, 1'b0, 14'd0);
        access("R7 read lo", A_RD, 8'h00, 1'b0, 14'd0);
        access("R9 cleared", A_ST, 8'h00, 1'b0, 14'd0);
        // R9 coincidence: strobe rises at the edge executing a read of 16
        pulse_lpen(14'h0123);
        access("R7 index", A_IDX, 8'd16, 1'b0, 14'd0);
        access("R9 coincide read", A_RD, 8'h00, 1'b1, 14'h3F81);
        access("R9 coincide flag", A_ST, 8'h00, 1'b0, 14'd0);
        access("R7 read new hi", A_RD, 8'h00, 1'b0, 14'd0);
        access("R9 flag cleared", A_ST, 8'h00, 1'b0, 14'd0);

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            if ($urandom_range(0, 9) < 8) a[14] = 1'b0;
            d = 8'($urandom);
            if (a[9:8] == 2'b00 && $urandom_range(0, 1) == 0) d[4:0] = 5'($urandom_range(12, 17));
            vborder = 1'($urandom);
            if ($urandom_range(0, 15) == 0) pulse_lpen(14'($urandom));
            access("R2 random", a, d, ($urandom_range(0, 19) == 0), 14'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule